// File: doc/BRIEF.md
# ATA Programmed-I/O Register Access Engine

This block is the host side of a parallel ATA bus for programmed-I/O register transfers. An internal requester asks for one of four operations: an 8-bit write, an 8-bit read, a 16-bit write to the data register, or a 16-bit read from the data register. Each request carries a register address. The engine presents the register-select lines and drives the active-low read or write strobe. It also steers the direction of the 16 data lines through a separate output-enable. When the transfer is over it returns a one-cycle done pulse, and for a read it also returns the captured data.

An access always runs through four phases: one address-setup cycle, a strobe-low phase of `STROBE_CYC` clocks, a recovery phase of `RECOV_CYC` clocks, and then a return to idle. 8-bit task-file accesses use only the low byte lane. 16-bit accesses are always sent to the data register, whatever address the request carries, and use both lanes.

Top module: `ata_pio_engine`

## Requirements
- R1: After reset both strobes are high, the data output-enable is low, busy is low, done is low and the read-data output is zero.
- R2: The read strobe and the write strobe are never low in the same cycle.
- R3: The register-address encoding works as follows. `req_addr[2:0]` drives the three address lines. `req_addr[3]=1` pulls the command-block select low, and `req_addr[4]=1` pulls the control-block select low. The address and select lines do not change while a strobe is low.
- R4: Kind 0 is an 8-bit write. It drives `wdata[7:0]` on the low lane and zero on the high lane, and this word is valid when the write strobe rises.
- R5: Kind 1 is an 8-bit read. It returns the low lane, zero-extended to 16 bits.
- R6: Kind 2 is a 16-bit write. Whatever the request address, it uses address 0 with the command-block select low and the control-block select high, and it drives all 16 bits.
- R7: Kind 3 is a 16-bit read. It uses the same fixed data-register address as R6 and returns all 16 lines.
- R8: Every strobe stays low for exactly `STROBE_CYC` clocks. After the strobe is released, `RECOV_CYC` busy clocks pass before done is raised.
- R9: The data output-enable is high only during a write access, including its setup cycle. It is low whenever the read strobe is low.
- R10: Done is high for exactly one clock, and busy is low in that same clock. A request presented while busy is high is ignored and causes no bus access.
- R11: The read-data output changes only when a read samples the bus. It holds its value until a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe; taken only while busy is low |
| req_kind | input | 2 | 0 byte write, 1 byte read, 2 word write, 3 word read |
| req_addr | input | 5 | [2:0] register offset, [3] command block, [4] control block |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Last read result |
| ata_da | output | 3 | Register address lines |
| ata_cs1_n | output | 1 | Command-block select, active low |
| ata_cs3_n | output | 1 | Control-block select, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_dd_out | output | 16 | Data driven toward the device |
| ata_dd_oe | output | 1 | Drive enable for ata_dd_out |
| ata_dd_in | input | 16 | Data received from the device |

## Verification
The bench drives the engine against a behavioural device model with a 32-entry register file. The model captures data on the rising edge of the write strobe, and while the read strobe is high it drives a marker value so that a sample taken at the wrong time shows up. Random mixes of the four kinds at random addresses separate these cases:
- lane handling: zero-extension of byte reads, and the zeroed high lane on byte writes;
- redirection of word accesses to the data register;
- address decoding across both chip selects.

Directed cases cover the following:
- a request raised while busy, to show it has no effect;
- idle cycles after a read, to show the read data holds;
- per-access measurement of strobe width and recovery length.

// File: rtl/ata_pio_engine.sv
module ata_pio_engine #(
  parameter int STROBE_CYC = 3,
  parameter int RECOV_CYC  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_kind,
  input  logic [4:0]  req_addr,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic [2:0]  ata_da,
  output logic        ata_cs1_n,
  output logic        ata_cs3_n,
  output logic        ata_diow_n,
  output logic        ata_dior_n,
  output logic [15:0] ata_dd_out,
  output logic        ata_dd_oe,
  input  logic [15:0] ata_dd_in
);
  localparam int MAXC = (STROBE_CYC > RECOV_CYC) ? STROBE_CYC : RECOV_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_RECOV} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          is_rd, is_word;
  logic [15:0]   wdata_q;

  assign busy       = (st != S_IDLE);
  assign ata_diow_n = !(st == S_STROBE && !is_rd);
  assign ata_dior_n = !(st == S_STROBE && is_rd);
  assign ata_dd_oe  = busy && !is_rd;
  assign ata_dd_out = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      is_rd     <= 1'b0;
      is_word   <= 1'b0;
      wdata_q   <= '0;
      ata_da    <= '0;
      ata_cs1_n <= 1'b1;
      ata_cs3_n <= 1'b1;
      rdata     <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          st      <= S_SETUP;
          is_rd   <= req_kind[0];
          is_word <= req_kind[1];
          if (req_kind[1]) begin
            ata_da    <= 3'd0;
            ata_cs1_n <= 1'b0;
            ata_cs3_n <= 1'b1;
            wdata_q   <= req_wdata;
          end else begin
            ata_da    <= req_addr[2:0];
            ata_cs1_n <= !req_addr[3];
            ata_cs3_n <= !req_addr[4];
            wdata_q   <= {8'h00, req_wdata[7:0]};
          end
        end
        S_SETUP: begin
          st  <= S_STROBE;
          cnt <= CW'(STROBE_CYC - 1);
        end
        S_STROBE: begin
          if (cnt == '0) begin
            st  <= S_RECOV;
            cnt <= CW'(RECOV_CYC - 1);
            if (is_rd) rdata <= is_word ? ata_dd_in : {8'h00, ata_dd_in[7:0]};
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_RECOV: begin
          if (cnt == '0) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_pio_engine_chk.sv
module ata_pio_engine_chk #(
  parameter int STROBE_CYC = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        busy,
  input logic        done,
  input logic [15:0] rdata,
  input logic [2:0]  ata_da,
  input logic        ata_cs1_n,
  input logic        ata_cs3_n,
  input logic        ata_diow_n,
  input logic        ata_dior_n,
  input logic        ata_dd_oe
);
  int wlow, rlow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlow <= 0;
      rlow <= 0;
    end else begin
      wlow <= ata_diow_n ? 0 : wlow + 1;
      rlow <= ata_dior_n ? 0 : rlow + 1;
    end
  end

  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_dior_n && !ata_diow_n));

  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_dior_n || !ata_diow_n) |=> (!ata_dior_n || !ata_diow_n) ? $stable({ata_da, ata_cs1_n, ata_cs3_n}) : 1'b1);

  a_r8_write_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ata_diow_n) |-> wlow == STROBE_CYC);

  a_r8_read_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ata_dior_n) |-> rlow == STROBE_CYC);

  a_r9_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_dior_n |-> !ata_dd_oe);

  a_r9_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_diow_n |-> ata_dd_oe);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> $stable(rdata));
endmodule

bind ata_pio_engine ata_pio_engine_chk #(.STROBE_CYC(STROBE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .rdata(rdata), .ata_da(ata_da), .ata_cs1_n(ata_cs1_n), .ata_cs3_n(ata_cs3_n),
  .ata_diow_n(ata_diow_n), .ata_dior_n(ata_dior_n), .ata_dd_oe(ata_dd_oe)
);

// File: tb/ata_pio_engine_tb.sv
module ata_pio_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SCYC = 3;
  localparam int RCYC = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_kind = 0;
  logic [4:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic busy, done;
  logic [15:0] rdata, dd_out, dd_in;
  logic [2:0] da;
  logic cs1_n, cs3_n, diow_n, dior_n, dd_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_pio_engine #(.STROBE_CYC(SCYC), .RECOV_CYC(RCYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .ata_da(da), .ata_cs1_n(cs1_n), .ata_cs3_n(cs3_n),
    .ata_diow_n(diow_n), .ata_dior_n(dior_n), .ata_dd_out(dd_out),
    .ata_dd_oe(dd_oe), .ata_dd_in(dd_in));

  // behavioural device: 32 registers indexed by {cs3_n, cs1_n, da}
  logic [15:0] dev_mem [32];
  logic [15:0] em [32];
  wire  [4:0]  dev_idx = {cs3_n, cs1_n, da};
  assign dd_in = !dior_n ? dev_mem[dev_idx] : 16'hDEAD;

  initial for (int i = 0; i < 32; i++) begin
    dev_mem[i] = 16'(i * 16'h1111) ^ 16'h5A00;
    em[i]      = 16'(i * 16'h1111) ^ 16'h5A00;
  end

  always @(posedge diow_n) if (rst_n && dd_oe) dev_mem[dev_idx] <= dd_out;

  int total = 0, bad = 0;
  int lowc = 0, gapc = 0, last_low = 0, last_gap = 0, oe_bad = 0, both_bad = 0;
  bit seen = 0;
  logic [4:0] sidx = 0, last_idx = 0;

  always @(negedge clk) if (rst_n) begin
    if (!dior_n && dd_oe) oe_bad++;
    if (!dior_n && !diow_n) both_bad++;
    if (!diow_n || !dior_n) begin lowc++; gapc = 0; seen = 1; sidx = dev_idx; end
    else if (busy && seen) gapc++;
    if (done) begin
      last_low = lowc; last_gap = gapc; last_idx = sidx;
      lowc = 0; gapc = 0; seen = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_idx(input logic [1:0] k, input logic [4:0] a);
    return k[1] ? 5'b10_000 : {~a[4], ~a[3], a[2:0]};
  endfunction

  function automatic logic [15:0] exp_read(input logic [1:0] k, input logic [15:0] v);
    return k[1] ? v : {8'h00, v[7:0]};
  endfunction

  task automatic xact(input logic [1:0] k, input logic [4:0] a, input logic [15:0] d,
                      output logic [15:0] r);
    @(negedge clk);
    req_valid = 1; req_kind = k; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    r = rdata;
    @(negedge clk);
    chk(!done, "R10 done single cycle", {31'd0, done}, 0);
    chk(last_low == SCYC, "R8 strobe width", last_low, SCYC);
    chk(last_gap == RCYC, "R8 recovery length", last_gap, RCYC);
    chk(last_idx == exp_idx(k, a), k[1] ? "R6 word address" : "R3 address decode",
        {27'd0, last_idx}, {27'd0, exp_idx(k, a)});
    if (!k[0]) em[exp_idx(k, a)] = k[1] ? d : {8'h00, d[7:0]};
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] r, held;
    logic [1:0] k;
    logic [4:0] a;
    logic [15:0] d;
    int dn;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(diow_n && dior_n && !dd_oe && !busy && !done && rdata == 0, "R1 reset state",
        {diow_n, dior_n, dd_oe, busy, done}, 5'b11000);
    rst_n = 1;

    // directed: byte write then byte read, high lane dropped
    xact(2'd0, 5'b01_101, 16'hBEEF, r);
    chk(dev_mem[5'b10_101] == 16'h00EF, "R4 byte write lanes", dev_mem[5'b10_101], 16'h00EF);
    xact(2'd1, 5'b01_101, 16'h0, r);
    chk(r == 16'h00EF, "R5 byte read", r, 16'h00EF);
    // byte read of a full-width preset value: zero extension
    xact(2'd1, 5'b10_110, 16'h0, r);
    chk(r == {8'h00, em[5'b01_110][7:0]}, "R5 zero extend", r, {8'h00, em[5'b01_110][7:0]});
    // word access with nonzero address goes to data register
    xact(2'd2, 5'b10_111, 16'hA55A, r);
    chk(dev_mem[5'b10_000] == 16'hA55A, "R6 word write", dev_mem[5'b10_000], 16'hA55A);
    xact(2'd3, 5'b01_011, 16'h0, r);
    chk(r == 16'hA55A, "R7 word read", r, 16'hA55A);

    // R11: read data holds over idle cycles and across writes
    held = rdata;
    repeat (5) @(negedge clk);
    chk(rdata == held, "R11 hold idle", rdata, held);
    xact(2'd0, 5'b01_001, 16'h0042, r);
    chk(rdata == held, "R11 hold across write", rdata, held);

    // R10: request while busy is ignored
    @(negedge clk);
    req_valid = 1; req_kind = 2'd0; req_addr = 5'b01_010; req_wdata = 16'h0011;
    @(negedge clk);
    req_kind = 2'd0; req_addr = 5'b01_100; req_wdata = 16'h00CC;
    @(negedge clk);
    req_valid = 0;
    dn = 0;
    repeat (SCYC + RCYC + 8) begin @(negedge clk); if (done) dn++; end
    chk(dn == 1, "R10 busy request ignored (done count)", dn, 1);
    em[5'b10_010] = 16'h0011;
    xact(2'd3, 5'b0, 16'h0, r);
    xact(2'd1, 5'b01_100, 16'h0, r);
    chk(r == {8'h00, em[5'b10_100][7:0]}, "R10 busy request no write", r, {8'h00, em[5'b10_100][7:0]});

    // random mix
    for (int i = 0; i < 80; i++) begin
      k = 2'($urandom_range(0, 3));
      a = 5'($urandom_range(0, 31));
      d = 16'($urandom);
      xact(k, a, d, r);
      if (k[0]) chk(r == exp_read(k, em[exp_idx(k, a)]), k[1] ? "R7 random word read" : "R5 random byte read",
                    r, exp_read(k, em[exp_idx(k, a)]));
      else chk(dev_mem[exp_idx(k, a)] == em[exp_idx(k, a)], k[1] ? "R6 random word write" : "R4 random byte write",
               dev_mem[exp_idx(k, a)], em[exp_idx(k, a)]);
    end

    chk(both_bad == 0, "R2 strobes exclusive", both_bad, 0);
    chk(oe_bad == 0, "R9 no drive during read", oe_bad, 0);
    finish_run();
  end
endmodule